// File: doc/BRIEF.md
# Pixel Hit Timestamp and Charge Counter

This block is the digital part of one pixel. It takes the output of the pixel's discriminator and turns each hit into a packed word. The word holds an arrival time and a charge measure, where the charge is measured as time over threshold. Arrival time has two parts. The coarse part is a copy of a shared time stamp that advances on every slow (40 MHz) clock edge. The fine part counts cycles of a fast clock (sixteen times the slow rate). That count starts at the hit and stops at the next slow edge. Subtracting the fine count from the coarse time, in units of 1/16 of a slow period, gives the finer arrival time.

The block runs on the fast clock. A one-cycle `sync_tick` input marks the fast cycle that holds a slow clock edge, and it must pulse once every 2^FT_W cycles. The `fast_req` output goes high only while the fine counter needs the fast clock. Outside the pixel, the requests of a group of pixels are ORed to start and stop their shared oscillator.

A second way of working is the counting mode. In that mode the same pixel counts discriminator hits and sums its time over threshold across one shutter window. When the shutter closes, it reports both totals in a single word. A hit word stays valid until the readout acknowledges it.

Top module: `pix_timer`

## Requirements
- R1: After reset `hit_valid` and `fast_req` are low.
- R2: In modes 2'b00, 2'b01 and 2'b11, a discriminator rising edge seen with `shutter` high and no word pending starts the fine interval. `fast_req` is high from the next cycle up to and including the next `sync_tick` cycle. The fine field holds the number of non-tick cycles in that interval (0 to 15).
- R3: The coarse field holds the value of `coarse_ts` in the `sync_tick` cycle that ends the fine interval.
- R4: In mode 2'b00 or 2'b11, the ToT field counts the `sync_tick` cycles after the fine-ending tick during which the discriminator stays high. It saturates at all ones. `hit_valid` rises one cycle after the discriminator is seen low.
- R5: In mode 2'b01 (ToA only) the word becomes valid at the fine-ending tick and its ToT field is zero.
- R6: In time modes the word is {pixel address [W-1:W-16], coarse [27:14], ToT, fine [FT_W-1:0]}, and the ToT field sits directly above the fine field.
- R7: A valid word holds steady until `rd_ack`. `hit_valid` is low in the cycle after `rd_ack`.
- R8: A discriminator rise is ignored while a word is pending, while a hit is being measured, or while `shutter` is low. After the pending word is read, no word appears for it.
- R9: In mode 2'b10 (counting), a discriminator rise with `shutter` high adds one to the event count. Each `sync_tick` with the discriminator and `shutter` high adds one to the integral ToT. Both totals saturate.
- R10: In counting mode a rising shutter clears both totals. A falling shutter presents {address, zeros, event count, integral ToT} with `hit_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low reset |
| sync_tick | input | 1 | Marks the fast cycle that holds a slow clock edge |
| coarse_ts | input | CT_W | Shared coarse time stamp |
| mode | input | 2 | 00/11 ToA+ToT, 01 ToA only, 10 counting |
| shutter | input | 1 | Acquisition window |
| discr | input | 1 | Discriminator output, synchronous to `clk` |
| pix_addr | input | ADDR_W | Pixel coordinate |
| rd_ack | input | 1 | Readout accepts the pending word |
| hit_valid | output | 1 | Word pending |
| hit_word | output | ADDR_W+CT_W+TOT_W+FT_W | Packed result |
| fast_req | output | 1 | Request for the shared fast oscillator |

## Verification
On every cycle, the embedded assertions check four things. The fast request drops after the tick that ends it. A pending word excludes any fast request, and that word holds steady until it is acknowledged. The ToT and event counters never wrap. Only the bench scenarios can show the values themselves: the fine count at each hit phase, the coarse value taken, the ToT counts, the totals in counting mode, and the dropping of hits that are ignored. For this, a behavioural model is compared against the outputs on every clock.

// File: rtl/pix_timer.sv
module pix_timer #(
  parameter int ADDR_W = 16,
  parameter int CT_W   = 14,
  parameter int FT_W   = 4,
  parameter int TOT_W  = 10,
  parameter int EC_W   = 10,
  parameter int IT_W   = 14,
  localparam int WORD_W = ADDR_W + CT_W + TOT_W + FT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_tick,
  input  logic [CT_W-1:0]   coarse_ts,
  input  logic [1:0]        mode,
  input  logic              shutter,
  input  logic              discr,
  input  logic [ADDR_W-1:0] pix_addr,
  input  logic              rd_ack,
  output logic              hit_valid,
  output logic [WORD_W-1:0] hit_word,
  output logic              fast_req
);
  localparam int PAD_W = WORD_W - ADDR_W - EC_W - IT_W;
  localparam logic [TOT_W-1:0] TOT_MAX = '1;
  localparam logic [EC_W-1:0]  EC_MAX  = '1;
  localparam logic [IT_W-1:0]  IT_MAX  = '1;

  typedef enum logic [1:0] {S_IDLE, S_FINE, S_TOT} st_t;

  st_t              st;
  logic             discr_q, shut_q;
  logic [FT_W-1:0]  fine;
  logic [CT_W-1:0]  crs;
  logic [TOT_W-1:0] tot;
  logic [EC_W-1:0]  evc;
  logic [IT_W-1:0]  itot;

  wire ev_mode  = (mode == 2'b10);
  wire toa_only = (mode == 2'b01);
  wire rise     = discr & ~discr_q;
  wire sh_rise  = shutter & ~shut_q;
  wire sh_fall  = ~shutter & shut_q;

  assign fast_req = (st == S_FINE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      discr_q   <= 1'b0;
      shut_q    <= 1'b0;
      fine      <= '0;
      crs       <= '0;
      tot       <= '0;
      evc       <= '0;
      itot      <= '0;
      hit_valid <= 1'b0;
      hit_word  <= '0;
    end else begin
      discr_q <= discr;
      shut_q  <= shutter;
      if (hit_valid && rd_ack) hit_valid <= 1'b0;
      if (ev_mode) begin
        if (sh_rise) begin
          evc  <= '0;
          itot <= '0;
        end else if (shutter) begin
          if (rise && evc != EC_MAX) evc <= evc + 1'b1;
          if (discr && sync_tick && itot != IT_MAX) itot <= itot + 1'b1;
        end
        if (sh_fall) begin
          hit_valid <= 1'b1;
          hit_word  <= {pix_addr, {PAD_W{1'b0}}, evc, itot};
        end
      end else begin
        case (st)
          S_IDLE: if (rise && shutter && !hit_valid) begin
            st   <= S_FINE;
            fine <= '0;
          end
          S_FINE: begin
            if (sync_tick) begin
              crs <= coarse_ts;
              tot <= '0;
              if (toa_only || !discr) begin
                st        <= S_IDLE;
                hit_valid <= 1'b1;
                hit_word  <= {pix_addr, coarse_ts, {TOT_W{1'b0}}, fine};
              end else begin
                st <= S_TOT;
              end
            end else begin
              fine <= fine + 1'b1;
            end
          end
          S_TOT: begin
            if (!discr) begin
              st        <= S_IDLE;
              hit_valid <= 1'b1;
              hit_word  <= {pix_addr, crs, tot, fine};
            end else if (sync_tick && tot != TOT_MAX) begin
              tot <= tot + 1'b1;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  a_r2_fast_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_req && sync_tick) |=> !fast_req);

  a_r8_pending_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |-> !fast_req);

  a_r7_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && !rd_ack && !(ev_mode && sh_fall)) |=> (hit_valid && $stable(hit_word)));

  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && rd_ack && !(ev_mode && sh_fall)) |=> !hit_valid);

  a_r4_tot_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TOT && tot == TOT_MAX) |=> tot == TOT_MAX);

  a_r9_evc_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_mode && !sh_rise && evc == EC_MAX) |=> evc == EC_MAX);

  a_r9_itot_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_mode && !sh_rise && itot == IT_MAX) |=> itot == IT_MAX);
endmodule

// File: tb/pix_timer_tb.sv
module pix_timer_tb;
  localparam int CLK_P  = 2;
  localparam int ADDR_W = 16;
  localparam int CT_W   = 14;
  localparam int FT_W   = 4;
  localparam int TOT_W  = 6;
  localparam int EC_W   = 5;
  localparam int IT_W   = 8;
  localparam int W      = ADDR_W + CT_W + TOT_W + FT_W;
  localparam int PER    = 1 << FT_W;
  localparam int TMAX   = (1 << TOT_W) - 1;
  localparam int EMAX   = (1 << EC_W) - 1;
  localparam int IMAX   = (1 << IT_W) - 1;

  logic clk = 0, rst_n = 0, sync_tick = 0, shutter = 0, discr = 0, rd_ack = 0;
  logic [CT_W-1:0] coarse_ts = 100;
  logic [1:0] mode = 2'b00;
  logic [ADDR_W-1:0] pix_addr = 16'hA5C3;
  logic hit_valid, fast_req;
  logic [W-1:0] hit_word;

  int total = 0, bad = 0, cyc = 0, phase = 0;
  bit running = 0;

  always #(CLK_P/2) clk = ~clk;

  pix_timer #(.ADDR_W(ADDR_W), .CT_W(CT_W), .FT_W(FT_W), .TOT_W(TOT_W),
              .EC_W(EC_W), .IT_W(IT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .sync_tick(sync_tick), .coarse_ts(coarse_ts),
    .mode(mode), .shutter(shutter), .discr(discr), .pix_addr(pix_addr),
    .rd_ack(rd_ack), .hit_valid(hit_valid), .hit_word(hit_word), .fast_req(fast_req));

  // behavioural reference
  int m_st, m_fine, m_crs, m_tot, m_ev, m_it;
  bit m_valid, m_dq, m_sq;
  logic [W-1:0] m_word;
  always @(posedge clk) begin
    bit rise, srise, sfall, oldv;
    if (!rst_n) begin
      m_st = 0; m_valid = 0; m_dq = 0; m_sq = 0; m_ev = 0; m_it = 0; m_word = '0;
      m_fine = 0; m_crs = 0; m_tot = 0;
    end else begin
      rise = discr && !m_dq; srise = shutter && !m_sq; sfall = !shutter && m_sq;
      m_dq = discr; m_sq = shutter; oldv = m_valid;
      if (m_valid && rd_ack) m_valid = 0;
      if (mode == 2'b10) begin
        if (srise) begin m_ev = 0; m_it = 0; end
        else if (shutter) begin
          if (rise && m_ev < EMAX) m_ev++;
          if (discr && sync_tick && m_it < IMAX) m_it++;
        end
        if (sfall) begin
          m_valid = 1;
          m_word = '0;
          m_word[W-1 -: ADDR_W] = pix_addr;
          m_word[EC_W+IT_W-1 -: EC_W] = m_ev[EC_W-1:0];
          m_word[IT_W-1:0] = m_it[IT_W-1:0];
        end
      end else if (m_st == 0) begin
        if (rise && shutter && !oldv) begin m_st = 1; m_fine = 0; end
      end else if (m_st == 1) begin
        if (sync_tick) begin
          m_crs = coarse_ts; m_tot = 0;
          if (mode == 2'b01 || !discr) begin
            m_st = 0; m_valid = 1;
            m_word = {pix_addr, coarse_ts, {TOT_W{1'b0}}, m_fine[FT_W-1:0]};
          end else m_st = 2;
        end else m_fine++;
      end else begin
        if (!discr) begin
          m_st = 0; m_valid = 1;
          m_word = {pix_addr, m_crs[CT_W-1:0], m_tot[TOT_W-1:0], m_fine[FT_W-1:0]};
        end else if (sync_tick && m_tot < TMAX) m_tot++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (running) begin
      chk(hit_valid == m_valid, "R7 model valid", hit_valid, m_valid);
      chk(fast_req == (m_st == 1), "R2 model fast_req", fast_req, m_st == 1);
      if (m_valid) chk(hit_word == m_word, "R6 model word", hit_word, m_word);
    end
    cyc++;
    phase = cyc % PER;
    sync_tick = (phase == PER - 1);
    if (phase == 0) coarse_ts = coarse_ts + 1'b1;
  endtask

  task automatic ack();
    rd_ack = 1; step(); rd_ack = 0;
    chk(!hit_valid, "R7 ack clears", hit_valid, 0);
  endtask

  // time-mode hit: rise in phase p, discriminator high for len cycles
  task automatic timed_hit(input int p, input int len, input bit toa);
    int fexp, texp, cexp;
    bit first;
    do step(); while (phase != p);
    discr = 1; first = 0; texp = 0; cexp = 0;
    fexp = (p == PER - 1) ? PER - 1 : PER - 2 - p;
    for (int i = 0; i < len; i++) begin
      if (sync_tick && i > 0) begin
        if (!first) begin first = 1; cexp = coarse_ts; end
        else if (texp < TMAX) texp++;
      end
      step();
      if (i == 0) chk(fast_req, "R2 fast_req after rise", fast_req, 1);
    end
    discr = 0;
    step();
    if (toa) texp = 0;
    chk(hit_valid, "R4 valid after fall", hit_valid, 1);
    chk(hit_word[FT_W-1:0] == fexp[FT_W-1:0], "R2 fine", hit_word[FT_W-1:0], fexp);
    chk(hit_word[CT_W+TOT_W+FT_W-1 -: CT_W] == cexp[CT_W-1:0], "R3 coarse",
        hit_word[CT_W+TOT_W+FT_W-1 -: CT_W], cexp);
    chk(hit_word[TOT_W+FT_W-1 -: TOT_W] == texp[TOT_W-1:0], toa ? "R5 tot zero" : "R4 tot",
        hit_word[TOT_W+FT_W-1 -: TOT_W], texp);
    chk(hit_word[W-1 -: ADDR_W] == pix_addr, "R6 address", hit_word[W-1 -: ADDR_W], pix_addr);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!hit_valid && !fast_req, "R1 reset outputs", {hit_valid, fast_req}, 0);
    rst_n = 1;
    running = 1;
    shutter = 1;
    step();

    timed_hit(3, 40, 0);  ack();
    timed_hit(15, 50, 0); ack();
    timed_hit(14, 20, 0); ack();
    timed_hit(0, 18, 0);  ack();
    timed_hit(7, PER * (TMAX + 5), 0);
    // R7: word held without acknowledge
    begin
      logic [W-1:0] held;
      held = hit_word;
      // R8: rise while pending is dropped
      discr = 1; step(); discr = 0;
      repeat (5) step();
      chk(hit_valid && hit_word == held, "R7 word held", hit_word, held);
    end
    ack();
    repeat (40) step();
    chk(!hit_valid, "R8 ignored hit left no word", hit_valid, 0);

    mode = 2'b01;
    timed_hit(5, 60, 1);
    ack();
    mode = 2'b11;
    timed_hit(9, 45, 0); ack();

    shutter = 0; step();
    discr = 1; repeat (40) step(); discr = 0; repeat (40) step();
    chk(!hit_valid && !fast_req, "R8 shutter low ignored", hit_valid, 0);

    // counting mode
    mode = 2'b10;
    for (int run = 0; run < 2; run++) begin
      int n, eexp, iexp;
      n = (run == 0) ? 7 : EMAX + 6;
      eexp = 0; iexp = 0;
      shutter = 1; step();
      for (int k = 0; k < n; k++) begin
        discr = 1; step(); discr = 0; step();
        if (eexp < EMAX) eexp++;
      end
      discr = 1;
      if (eexp < EMAX) eexp++;
      for (int k = 0; k < PER * (run == 0 ? 5 : IMAX + 4); k++) begin
        if (sync_tick && iexp < IMAX) iexp++;
        step();
      end
      discr = 0; step();
      shutter = 0; step();
      chk(hit_valid, "R10 word on shutter fall", hit_valid, 1);
      chk(hit_word[EC_W+IT_W-1 -: EC_W] == eexp[EC_W-1:0], "R9 event count",
          hit_word[EC_W+IT_W-1 -: EC_W], eexp);
      chk(hit_word[IT_W-1:0] == iexp[IT_W-1:0], "R9 integral tot", hit_word[IT_W-1:0], iexp);
      chk(hit_word[W-1 -: ADDR_W] == pix_addr, "R10 address", hit_word[W-1 -: ADDR_W], pix_addr);
      ack();
    end
    // R10: a third short window starts from zero
    shutter = 1; step();
    discr = 1; step(); discr = 0; step();
    shutter = 0; step();
    chk(hit_word[EC_W+IT_W-1 -: EC_W] == 1, "R10 cleared on open",
        hit_word[EC_W+IT_W-1 -: EC_W], 1);
    ack();
    repeat (4) step();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule